// File: doc/BRIEF.md
# Chained-Descriptor Capture DMA Channel

This block is one DMA channel that moves image data from a capture FIFO into memory buffers. It follows a linked list of descriptors held in memory. Each descriptor is four 32-bit words. One word points at the next descriptor, one gives the target buffer address, and one is a command word that holds a byte count and a completion-interrupt enable. Software extends the list while the channel runs. It does this by rewriting the last descriptor of the tail buffer from a terminator, which points at a reserved stop address, into a zero-length link that points at the next buffer.

A walk begins in one of two ways. Software can arm the channel, which then waits for the next frame-boundary pulse. Software can also kick it directly, which starts the walk at once. The channel halts when it loads the stop address as its next pointer. Software can read the current next-pointer at any moment. If it reads the stop address while buffers are still queued, the last append came too late. Software then kicks the channel again at the first pending descriptor.

Top module: `lddma_channel`

## Requirements
- R1: After reset, `run`, `armed`, `end_flag`, `err` and `irq` are 0, and `cur_next` holds the stop address 0x00000001.
- R2: A kick with `sw_wait_frame`=1 sets `armed` and loads `sw_first` into `cur_next`. No descriptor read and no data write take place until a `frame_end` pulse arrives, and the walk then begins at `sw_first`.
- R3: A descriptor at address A is fetched as four word reads in the order A, A+4, A+8, A+12. The words are, in that order: the next pointer, a source word that is ignored, the target address, and the command. In the command, bits [12:0] give the byte length and bit 21 is the end-interrupt enable.
- R4: A descriptor of length L writes L/8 beats of 64 bits each. The beats go to the target address, then target+8, and so on in order. Each beat carries the FIFO word that was present when that beat was taken.
- R5: While `fifo_empty` is 1 during a transfer, no beat is written and the channel keeps its address and remaining count. The transfer continues from that point when data returns.
- R6: A descriptor whose command is zero writes no data. The channel follows its next pointer to the next descriptor.
- R7: When a descriptor completes, its next pointer is loaded into `cur_next`. If that pointer is the stop address, `run` falls to 0 in the same cycle that the stop address appears in `cur_next`.
- R8: When a descriptor with the enable bit completes, `end_flag` is set. Pulsing `end_clr` clears it. `irq` equals `end_flag` AND `irq_en`.
- R9: A length that is not a multiple of 8 sets `err`, halts the channel, and writes no data for that descriptor. The next kick clears `err`.
- R10: A kick with `sw_wait_frame`=0 starts the walk at once from `sw_first`, without waiting for a frame pulse. This is how a missed append is recovered.
- R11: A kick while the channel is walking or armed is ignored. A `frame_end` pulse while the channel is idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_kick | input | 1 | One-cycle pulse that starts or arms the channel |
| sw_wait_frame | input | 1 | Selects the kick mode: 1 arms and waits for a frame pulse, 0 starts at once |
| sw_first | input | 32 | Address of the first descriptor, used on a kick |
| frame_end | input | 1 | Frame-boundary pulse |
| end_clr | input | 1 | Write-one-to-clear strobe for `end_flag` |
| irq_en | input | 1 | Interrupt enable |
| desc_rd_en | output | 1 | Descriptor word read request |
| desc_rd_addr | output | 32 | Descriptor word byte address |
| desc_rd_data | input | 32 | Read data, returned one cycle after the request |
| fifo_empty | input | 1 | The capture FIFO has no data |
| fifo_data | input | 64 | Head word of the capture FIFO (show-ahead) |
| fifo_pop | output | 1 | Takes the head word from the FIFO |
| wr_en | output | 1 | Beat write strobe |
| wr_addr | output | 32 | Beat write byte address |
| wr_data | output | 64 | Beat write data |
| run | output | 1 | High while the channel is walking descriptors |
| armed | output | 1 | High while the channel waits for a frame pulse |
| cur_next | output | 32 | Current next-descriptor pointer |
| end_flag | output | 1 | Sticky end-of-chain status |
| err | output | 1 | Sticky length-alignment error |
| irq | output | 1 | Interrupt output |

## Verification
The single-descriptor table checks how the length and enable bit of the command word work together. A single beat, a full buffer, a buffer with the enable bit clear, a misaligned length, a zero-length terminator and the largest length each give a different beat count, flag, error and final pointer. A three-descriptor chain with a link in the middle shows that a link moves nothing and that the chain still runs on to the next buffer. A FIFO that is held empty partway through a buffer, with a stray kick during the stall, shows the difference between a channel that keeps its position and one that skips or restarts. Arming with a delayed frame pulse and a direct restart after the stop address has been read show the difference between the two ways a walk can start.

// File: rtl/lddma_pkg.sv
package lddma_pkg;
   localparam int unsigned DESC_WORD_W = 32;
   localparam int unsigned DESC_WORDS  = 4;

   typedef enum logic [2:0] {
      CH_IDLE,
      CH_ARMED,
      CH_LAUNCH,
      CH_FETCH,
      CH_MOVE,
      CH_RETIRE
   } ch_state_t;
endpackage

// File: rtl/lddma_fetch.sv
module lddma_fetch #(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 13,
   parameter int unsigned IEN_POS = 21
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  go,
   input  logic [AW-1:0]                         base,
   output logic                                  rd_en,
   output logic [AW-1:0]                         rd_addr,
   input  logic [lddma_pkg::DESC_WORD_W-1:0]     rd_data,
   output logic                                  done,
   output logic [AW-1:0]                         d_next,
   output logic [AW-1:0]                         d_tgt,
   output logic [LEN_W-1:0]                      d_len,
   output logic                                  d_ien
);
   localparam int unsigned IW = $clog2(lddma_pkg::DESC_WORDS) + 1;

   logic            busy_q;
   logic [IW-1:0]   issue_q;
   logic [AW-1:0]   base_q;
   logic            cap_vld_q;
   logic [IW-2:0]   cap_idx_q;
   logic            done_q;

   assign rd_en   = busy_q && !issue_q[IW-1];
   assign rd_addr = base_q + AW'({issue_q[IW-2:0], 2'b00});
   assign done    = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         issue_q   <= '0;
         base_q    <= '0;
         cap_vld_q <= 1'b0;
         cap_idx_q <= '0;
         done_q    <= 1'b0;
         d_next    <= '0;
         d_tgt     <= '0;
         d_len     <= '0;
         d_ien     <= 1'b0;
      end else begin
         cap_vld_q <= rd_en;
         cap_idx_q <= issue_q[IW-2:0];
         done_q    <= cap_vld_q && (cap_idx_q == (IW-1)'(lddma_pkg::DESC_WORDS - 1));
         if (go) begin
            busy_q  <= 1'b1;
            issue_q <= '0;
            base_q  <= base;
         end else if (rd_en) begin
            issue_q <= issue_q + IW'(1);
            if (issue_q == IW'(lddma_pkg::DESC_WORDS - 1)) busy_q <= 1'b0;
         end
         if (cap_vld_q) begin
            case (cap_idx_q)
               (IW-1)'(0): d_next <= rd_data[AW-1:0];
               (IW-1)'(2): d_tgt  <= rd_data[AW-1:0];
               (IW-1)'(3): begin
                  d_len <= rd_data[LEN_W-1:0];
                  d_ien <= rd_data[IEN_POS];
               end
               default: ;
            endcase
         end
      end
   end

   // Consecutive reads in one fetch step through the words in order (R3)
   p_word_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(4)));
endmodule

// File: rtl/lddma_mover.sv
module lddma_mover #(
   parameter int unsigned AW = 32,
   parameter int unsigned BW = 64,
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] tgt,
   input  logic [CW-1:0] beats,
   input  logic          fifo_empty,
   input  logic [BW-1:0] fifo_data,
   output logic          fifo_pop,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [BW-1:0] wr_data,
   output logic          done
);
   localparam int unsigned BB = BW / 8;

   logic          busy_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] remain_q;
   logic          done_q;

   assign fifo_pop = busy_q && !fifo_empty;
   assign wr_en    = fifo_pop;
   assign wr_addr  = addr_q;
   assign wr_data  = fifo_data;
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         addr_q   <= '0;
         remain_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            busy_q   <= 1'b1;
            addr_q   <= tgt;
            remain_q <= beats;
         end else if (fifo_pop) begin
            addr_q   <= addr_q + AW'(BB);
            remain_q <= remain_q - CW'(1);
            if (remain_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // An empty FIFO freezes the transfer position (R5)
   p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && fifo_empty && !go) |=> ($stable(addr_q) && $stable(remain_q)));
endmodule

// File: rtl/lddma_channel.sv
module lddma_channel #(
   parameter int unsigned  AW        = 32,
   parameter int unsigned  BW        = 64,
   parameter int unsigned  LEN_W     = 13,
   parameter int unsigned  IEN_POS   = 21,
   parameter logic [AW-1:0] STOP_PTR = 'h1,
   parameter bit           IRQ_REG   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_kick,
   input  logic          sw_wait_frame,
   input  logic [AW-1:0] sw_first,
   input  logic          frame_end,
   input  logic          end_clr,
   input  logic          irq_en,
   output logic          desc_rd_en,
   output logic [AW-1:0] desc_rd_addr,
   input  logic [31:0]   desc_rd_data,
   input  logic          fifo_empty,
   input  logic [BW-1:0] fifo_data,
   output logic          fifo_pop,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [BW-1:0] wr_data,
   output logic          run,
   output logic          armed,
   output logic [AW-1:0] cur_next,
   output logic          end_flag,
   output logic          err,
   output logic          irq
);
   import lddma_pkg::*;

   localparam int unsigned BB = BW / 8;
   localparam int unsigned SH = $clog2(BB);
   localparam int unsigned CW = LEN_W - SH;

   if (BW % 8 != 0 || (1 << SH) != BB)
      $error("beat width must be a power-of-two number of bytes");
   if (AW > DESC_WORD_W) $error("address wider than a descriptor word");
   if (IEN_POS < LEN_W || IEN_POS >= DESC_WORD_W) $error("enable bit overlaps length");
   if (LEN_W <= SH) $error("length field narrower than one beat");

   ch_state_t      st_q;
   logic [AW-1:0]  next_q;
   logic           flag_q, err_q;

   logic           f_go, f_done, d_ien;
   logic [AW-1:0]  d_next, d_tgt;
   logic [LEN_W-1:0] d_len;
   logic           m_go, m_done;
   logic           len_bad, len_zero, retire_ien;

   assign f_go       = (st_q == CH_LAUNCH) && (next_q != STOP_PTR);
   assign len_bad    = |d_len[SH-1:0];
   assign len_zero   = (d_len == '0);
   assign m_go       = (st_q == CH_FETCH) && f_done && !len_bad && !len_zero;
   assign retire_ien = (st_q == CH_RETIRE) && d_ien;

   lddma_fetch #(.AW(AW), .LEN_W(LEN_W), .IEN_POS(IEN_POS)) i_fetch (
      .clk(clk), .rst_n(rst_n), .go(f_go), .base(next_q),
      .rd_en(desc_rd_en), .rd_addr(desc_rd_addr), .rd_data(desc_rd_data),
      .done(f_done), .d_next(d_next), .d_tgt(d_tgt), .d_len(d_len), .d_ien(d_ien)
   );

   lddma_mover #(.AW(AW), .BW(BW), .CW(CW)) i_mover (
      .clk(clk), .rst_n(rst_n), .go(m_go), .tgt(d_tgt), .beats(d_len[LEN_W-1:SH]),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(m_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CH_IDLE;
         next_q <= STOP_PTR;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            CH_IDLE: if (sw_kick) begin
               next_q <= sw_first;
               err_q  <= 1'b0;
               st_q   <= sw_wait_frame ? CH_ARMED : CH_LAUNCH;
            end
            CH_ARMED:  if (frame_end) st_q <= CH_LAUNCH;
            CH_LAUNCH: st_q <= (next_q == STOP_PTR) ? CH_IDLE : CH_FETCH;
            CH_FETCH: if (f_done) begin
               if (len_bad) begin
                  err_q <= 1'b1;
                  st_q  <= CH_IDLE;
               end else begin
                  st_q  <= len_zero ? CH_RETIRE : CH_MOVE;
               end
            end
            CH_MOVE:   if (m_done) st_q <= CH_RETIRE;
            CH_RETIRE: begin
               next_q <= d_next;
               st_q   <= (d_next == STOP_PTR) ? CH_IDLE : CH_LAUNCH;
            end
            default:   st_q <= CH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (retire_ien) flag_q <= 1'b1;
      else if (end_clr)    flag_q <= 1'b0;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q && irq_en;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = flag_q && irq_en;
   end

   assign run      = (st_q != CH_IDLE) && (st_q != CH_ARMED);
   assign armed    = (st_q == CH_ARMED);
   assign cur_next = next_q;
   assign end_flag = flag_q;
   assign err      = err_q;

   // Stop pointer loaded means run drops in the same cycle (R7)
   p_stop_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_RETIRE && d_next == STOP_PTR) |=> (!run && cur_next == STOP_PTR));
   // An armed channel touches neither memory nor the FIFO (R2)
   p_armed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (!desc_rd_en && !wr_en && !fifo_pop));
   // A misaligned length halts with no write (R9)
   p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!run && !wr_en));
   // Write-one-to-clear of the end flag (R8)
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (end_flag && end_clr && !retire_ien) |=> !end_flag);
endmodule

// File: tb/test_lddma_channel.sv
module test_lddma_channel;
   localparam logic [31:0] STOP = 32'h1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_kick = 1'b0, sw_wait_frame = 1'b0;
   logic [31:0] sw_first = '0;
   logic        frame_end = 1'b0, end_clr = 1'b0, irq_en = 1'b0;
   logic        desc_rd_en;
   logic [31:0] desc_rd_addr;
   logic [31:0] desc_rd_data = '0;
   logic        fifo_block = 1'b0;
   logic [31:0] pop_ctr = '0;
   logic        fifo_pop, wr_en, run, armed, end_flag, err, irq;
   logic [31:0] wr_addr, cur_next;
   logic [63:0] wr_data;

   always #4 clk = ~clk;

   lddma_channel i_lddma_channel (
      .clk(clk), .rst_n(rst_n), .sw_kick(sw_kick), .sw_wait_frame(sw_wait_frame),
      .sw_first(sw_first), .frame_end(frame_end), .end_clr(end_clr), .irq_en(irq_en),
      .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
      .fifo_empty(fifo_block), .fifo_data({32'hFEED0000, pop_ctr}), .fifo_pop(fifo_pop),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .run(run), .armed(armed),
      .cur_next(cur_next), .end_flag(end_flag), .err(err), .irq(irq)
   );

   logic [31:0] dmem [64];
   int          rd_cnt = 0;
   logic [31:0] rd_log [4];
   int          wr_cnt = 0;
   logic [31:0] last_wr_addr = '0;
   logic [63:0] first_wr_data = '0;
   bit          contig_bad = 1'b0;
   int          checks = 0, fails = 0;

   always @(posedge clk) begin
      if (desc_rd_en) begin
         desc_rd_data <= dmem[desc_rd_addr[7:2]];
         if (rd_cnt < 4) rd_log[rd_cnt] = desc_rd_addr;
         rd_cnt++;
      end
      if (fifo_pop) pop_ctr <= pop_ctr + 1;
      if (wr_en) begin
         if (wr_cnt > 0 && wr_addr != last_wr_addr + 8) contig_bad = 1'b1;
         if (wr_cnt == 0) first_wr_data = wr_data;
         last_wr_addr = wr_addr;
         wr_cnt++;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] tgt,
                           input logic [31:0] cmd);
      dmem[a[7:2]]     = nxt;
      dmem[a[7:2] + 1] = 32'hDEADBEEF;
      dmem[a[7:2] + 2] = tgt;
      dmem[a[7:2] + 3] = cmd;
   endtask

   task automatic clr_log();
      rd_cnt = 0; wr_cnt = 0; contig_bad = 1'b0;
   endtask

   task automatic kick(input logic wait_fr, input logic [31:0] first);
      @(negedge clk);
      sw_kick = 1'b1; sw_wait_frame = wait_fr; sw_first = first;
      @(negedge clk);
      sw_kick = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); end_clr = 1'b1;
      @(negedge clk); end_clr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 5000; n++) begin
         @(negedge clk);
         if (!run && !armed) break;
      end
   endtask

   // Vector: [14] expected error, [13] end-interrupt enable, [12:0] byte length
   localparam logic [14:0] VECS [6] = '{
      {1'b0, 1'b1, 13'd8},
      {1'b0, 1'b1, 13'd64},
      {1'b0, 1'b0, 13'd24},
      {1'b1, 1'b1, 13'd12},
      {1'b0, 1'b1, 13'd0},
      {1'b0, 1'b0, 13'd8184}
   };

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] pc0;
      int          c0;
      for (int i = 0; i < 64; i++) dmem[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!run && !armed && !end_flag && !err && !irq, "R1 reset flags",
          {run, armed, end_flag, err, irq}, 0);
      chk(cur_next == STOP, "R1 reset pointer", cur_next, STOP);

      // Table of single-descriptor chains (R3 R4 R7 R8 R9 R6)
      for (int v = 0; v < 6; v++) begin
         logic [12:0] len;
         logic        ien, xerr;
         int          xbeats;
         len = VECS[v][12:0]; ien = VECS[v][13]; xerr = VECS[v][14];
         xbeats = xerr ? 0 : int'(len) / 8;
         put_desc(32'h40, STOP, 32'h100, {10'b0, ien, 8'b0, len});
         clr_log();
         pc0 = pop_ctr;
         kick(1'b0, 32'h40);
         wait_idle();
         chk(wr_cnt == xbeats, $sformatf("R4 beat count v%0d", v), wr_cnt, xbeats);
         chk(err == xerr, $sformatf("R9 error v%0d", v), err, xerr);
         chk(end_flag == (ien && !xerr), $sformatf("R8 end flag v%0d", v), end_flag, ien && !xerr);
         chk(cur_next == (xerr ? 32'h40 : STOP), $sformatf("R7 pointer v%0d", v),
             cur_next, xerr ? 32'h40 : STOP);
         chk(!run, $sformatf("R7 halted v%0d", v), run, 0);
         if (xbeats > 0) begin
            chk(last_wr_addr == 32'h100 + len - 8 && !contig_bad,
                $sformatf("R4 addresses v%0d", v), last_wr_addr, 32'h100 + len - 8);
            chk(first_wr_data == {32'hFEED0000, pc0}, $sformatf("R4 data v%0d", v),
                first_wr_data, {32'hFEED0000, pc0});
         end
         if (v == 0)
            chk(rd_log[0] == 32'h40 && rd_log[1] == 32'h44 && rd_log[2] == 32'h48 &&
                rd_log[3] == 32'h4C && rd_cnt == 4, "R3 fetch order", rd_log[3], 32'h4C);
         pulse_clr();
      end

      // R11 frame pulse while idle is ignored
      clr_log();
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      repeat (3) @(negedge clk);
      chk(!run && rd_cnt == 0, "R11 idle frame ignored", rd_cnt, 0);

      // R2 arm then frame pulse
      put_desc(32'h40, STOP, 32'h100, 32'h0020_0010);
      clr_log();
      kick(1'b1, 32'h40);
      repeat (10) @(negedge clk);
      chk(armed && !run && rd_cnt == 0 && wr_cnt == 0, "R2 waits for frame",
          {armed, run}, 2'b10);
      chk(cur_next == 32'h40, "R2 pointer loaded", cur_next, 32'h40);
      kick(1'b0, 32'h80);
      chk(armed && rd_cnt == 0, "R11 kick while armed ignored", rd_cnt, 0);
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      wait_idle();
      chk(wr_cnt == 2 && rd_log[0] == 32'h40, "R2 walk after frame", wr_cnt, 2);
      pulse_clr();

      // R6 chain with a zero-length link in the middle
      put_desc(32'h40, 32'h50, 32'h100, 32'h0000_0010);
      put_desc(32'h50, 32'h60, 32'h0, 32'h0);
      put_desc(32'h60, STOP, 32'h200, 32'h0020_0008);
      clr_log();
      kick(1'b0, 32'h40);
      wait_idle();
      chk(wr_cnt == 3 && last_wr_addr == 32'h200, "R6 link moves nothing", wr_cnt, 3);
      chk(rd_cnt == 12, "R6 three fetches", rd_cnt, 12);
      chk(end_flag && cur_next == STOP, "R7 chain end", cur_next, STOP);

      // R8 interrupt gating and write-one-to-clear
      @(negedge clk);
      chk(!irq, "R8 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq, "R8 irq enabled", irq, 1);
      pulse_clr();
      chk(!end_flag && !irq, "R8 flag cleared", {end_flag, irq}, 0);
      irq_en = 1'b0;

      // R5 stall on empty FIFO, with a stray kick (R11)
      put_desc(32'h40, STOP, 32'h100, 32'h0000_0040);
      put_desc(32'h80, STOP, 32'h300, 32'h0000_0008);
      clr_log();
      fifo_block = 1'b1;
      kick(1'b0, 32'h40);
      repeat (15) @(negedge clk);
      chk(run && wr_cnt == 0, "R5 stalled at start", wr_cnt, 0);
      fifo_block = 1'b0;
      repeat (3) @(negedge clk);
      fifo_block = 1'b1;
      c0 = wr_cnt;
      kick(1'b0, 32'h80);
      repeat (10) @(negedge clk);
      chk(run && wr_cnt == c0 && c0 == 3, "R5 holds position", wr_cnt, c0);
      fifo_block = 1'b0;
      wait_idle();
      chk(wr_cnt == 8 && last_wr_addr == 32'h138 && !contig_bad, "R5 resumed in order",
          last_wr_addr, 32'h138);
      chk(rd_cnt == 4 && rd_log[0] == 32'h40, "R11 kick while running ignored", rd_cnt, 4);

      // R10 missed append: pointer reads stop, software restarts directly
      chk(cur_next == STOP, "R10 stop seen", cur_next, STOP);
      put_desc(32'h60, STOP, 32'h200, 32'h0000_0008);
      clr_log();
      kick(1'b0, 32'h60);
      chk(run, "R10 starts without frame", run, 1);
      wait_idle();
      chk(wr_cnt == 1 && last_wr_addr == 32'h200, "R10 restarted buffer", last_wr_addr, 32'h200);

      summary();
      $finish;
   end
endmodule